// File: doc/BRIEF.md
# Gauge Register Reset Sequencer

This block decides when the state registers of a battery gauge are to be reset. It sits beside the register file and watches the register write bus (address, data and write strobe). A reset is requested by software through an exact two-step command: a zero written to the arming address, then a zero written to the firing address. Any other write in between cancels the request.

A second, timed path gives a hardware reset when the gauge has lost its supply and its backup pin is held grounded. The block counts one-second ticks while both conditions hold. When 15 consecutive ticks have been seen, it fires.

Both paths drive a single-cycle reset pulse into the register file. A two-bit status output records which path caused the most recent reset.

Top module: `gauge_rst_seq`

## Requirements
- R1: After `rst_n` is released, `reset_pulse` is 0 and `reset_src` is 2'b00 (no reset yet).
- R2: A write of 8'h00 to address 8'h1E arms the sequence. A later write of 8'h00 to address 8'h05, with no other write in between, makes `reset_pulse` high for exactly one cycle, in the cycle after that write is sampled. It also sets `reset_src` to 2'b01 (command).
- R3: While armed, three kinds of write disarm the sequence: a nonzero write to 8'h1E, a write to any address other than 8'h1E and 8'h05, or a nonzero write to 8'h05. A following 8'h00 write to 8'h05 then gives no reset. A repeated 8'h00 write to 8'h1E keeps the sequence armed.
- R4: A write of 8'h00 to 8'h05 while not armed gives no reset pulse and leaves `reset_src` unchanged.
- R5: A command reset returns the sequence to idle. A second 8'h00 write to 8'h05 after it gives no reset unless 8'h1E is armed again.
- R6: The hardware path counts a `sec_tick` only while `supply_ok` is 0 and `backup_gnd` is 1. The 15th such tick makes `reset_pulse` high for one cycle in the cycle after that tick and sets `reset_src` to 2'b10 (hardware). If either condition is absent, no ticks are counted.
- R7: If either condition drops before the 15th tick, the count restarts from zero. A full 15 further ticks are then needed.
- R8: A hold that lasts beyond the firing tick produces no further pulse until the conditions have dropped and been met again.
- R9: If both paths fire in the same cycle, one pulse is produced and `reset_src` is 2'b10. A hardware reset also disarms the command sequence.
- R10: `reset_src` keeps its value until the next reset pulse.
- R11: Address and data seen while `wr_en` is 0 have no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_tick | input | 1 | One-cycle pulse once per second |
| supply_ok | input | 1 | 1 when the main supply is present |
| backup_gnd | input | 1 | 1 when the backup pin is detected grounded |
| reset_pulse | output | 1 | One-cycle reset to the register file |
| reset_src | output | 2 | Source of last reset: 00 none, 01 command, 10 hardware |

## Verification
The bench targets the ways the command sequence can be broken:
- A zero written to the firing address with no arming. A design that treats the firing write alone as a command resets on ordinary writes.
- A foreign write, a nonzero write, or a strobe-less bus cycle between the two steps. A design that forgets to disarm resets when it should not.
- A second firing write after a reset. A design that stays armed resets twice.

On the timed path it checks several boundaries:
- A hold that drops after 14 ticks and then restarts. A counter that fails to clear fires early.
- A hold that lasts past the firing tick. A design with no once-per-hold guard pulses repeatedly.
- A hold with only one of the two conditions present. A design that ignores one condition counts when it should not.

Finally, it makes both paths fire in the same cycle. A design without clear priority gives two pulses or the wrong source code.

// File: rtl/gauge_rst_pkg.sv
package gauge_rst_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_CMD  = 2'b01,
        SRC_HW   = 2'b10
    } rst_src_e;

endpackage

// File: rtl/gauge_rst_cmd_seq.sv
module gauge_rst_cmd_seq #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] ARM_ADDR  = 8'h1E,
    parameter logic [ADDR_W-1:0] FIRE_ADDR = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              disarm,
    output logic              cmd_hit
);

    typedef struct packed {
        logic armed;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic       data_zero;

    assign data_zero = (wr_data == '0);

    always_comb begin
        st_d    = st_q;
        cmd_hit = 1'b0;
        if (wr_en) begin
            if (wr_addr == ARM_ADDR) begin
                st_d.armed = data_zero;
            end else if (st_q.armed && wr_addr == FIRE_ADDR && data_zero) begin
                cmd_hit    = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b0;
            end
        end
        if (disarm) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_UNARMED_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed) |-> !cmd_hit);  // R4

    AST_FOREIGN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ARM_ADDR) |=> !st_q.armed);  // R3

    AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !disarm) |=> $stable(st_q.armed));  // R11

endmodule

// File: rtl/gauge_rst_hold_timer.sv
module gauge_rst_hold_timer #(
    parameter int HOLD_SECONDS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic supply_ok,
    input  logic backup_gnd,
    output logic hw_hit
);

    localparam int CNT_W = $clog2(HOLD_SECONDS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_SECONDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } hold_state_t;

    hold_state_t st_q, st_d;
    logic        hold_cond;

    assign hold_cond = !supply_ok && backup_gnd;

    always_comb begin
        st_d   = st_q;
        hw_hit = 1'b0;
        if (!hold_cond) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (sec_tick && !st_q.done) begin
            if (st_q.cnt == LAST_CNT) begin
                hw_hit    = 1'b1;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);  // R7

    AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok || !backup_gnd) |=> (st_q.cnt == '0));  // R7

    AST_ONE_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_hit && hold_cond) |=> (hold_cond |-> !hw_hit));  // R8

endmodule

// File: rtl/gauge_rst_seq.sv
module gauge_rst_seq #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int HOLD_SECONDS = 15,
    parameter bit HW_PATH_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sec_tick,
    input  logic              supply_ok,
    input  logic              backup_gnd,
    output logic              reset_pulse,
    output logic [1:0]        reset_src
);

    import gauge_rst_pkg::*;

    typedef struct packed {
        logic     pulse;
        rst_src_e src;
    } out_state_t;

    out_state_t st_q, st_d;
    logic       cmd_hit;
    logic       hw_hit;

    gauge_rst_cmd_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ARM_ADDR  (ADDR_W'(8'h1E)),
        .FIRE_ADDR (ADDR_W'(8'h05))
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .disarm  (hw_hit),
        .cmd_hit (cmd_hit)
    );

    generate
        if (HW_PATH_EN) begin : g_hw
            gauge_rst_hold_timer #(
                .HOLD_SECONDS (HOLD_SECONDS)
            ) u_hold (
                .clk        (clk),
                .rst_n      (rst_n),
                .sec_tick   (sec_tick),
                .supply_ok  (supply_ok),
                .backup_gnd (backup_gnd),
                .hw_hit     (hw_hit)
            );
        end else begin : g_no_hw
            logic unused_hw;
            assign unused_hw = sec_tick ^ supply_ok ^ backup_gnd;
            assign hw_hit    = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.pulse = cmd_hit || hw_hit;
        if (hw_hit) begin
            st_d.src = SRC_HW;
        end else if (cmd_hit) begin
            st_d.src = SRC_CMD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pulse: 1'b0, src: SRC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign reset_pulse = st_q.pulse;
    assign reset_src   = st_q.src;

    AST_PULSE_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (reset_src != SRC_NONE));  // R2

    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_pulse |-> $stable(reset_src));  // R10

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> (reset_pulse && reset_src == SRC_HW));  // R9

endmodule

// File: tb/gauge_rst_seq_tb.sv
module gauge_rst_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sec_tick = 1'b0;
    logic       supply_ok = 1'b1;
    logic       backup_gnd = 1'b0;
    logic       reset_pulse;
    logic [1:0] reset_src;

    typedef struct {
        int         cyc;
        logic [1:0] src;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_pulse = 0;
    int   n_exp = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gauge_rst_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sec_tick    (sec_tick),
        .supply_ok   (supply_ok),
        .backup_gnd  (backup_gnd),
        .reset_pulse (reset_pulse),
        .reset_src   (reset_src)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a pulse appears.
    always @(negedge clk) begin
        if (rst_n && reset_pulse) begin
            n_pulse++;
            if (exp_q.size() == 0) begin
                check("R3/R4/R5/R8 unexpected pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2/R6 pulse cycle", cyc, e.cyc);
                check("R2/R6/R9 pulse source", int'(reset_src), int'(e.src));
            end
        end
    end

    task automatic push(input logic [1:0] src);
        exp_t e;
        e.cyc = cyc + 1;
        e.src = src;
        exp_q.push_back(e);
        n_exp++;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                             input bit expect_rst);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (expect_rst) push(2'b01);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(input bit expect_rst);
        @(posedge clk); #1;
        sec_tick = 1'b1;
        if (expect_rst) push(2'b10);
        @(posedge clk); #1;
        sec_tick = 1'b0;
    endtask

    task automatic set_cond(input logic s, input logic b);
        @(posedge clk); #1;
        supply_ok = s; backup_gnd = b;
    endtask

    task automatic settle(input string req);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, n_pulse, n_exp);
        check({req, " scoreboard drained"}, exp_q.size(), 0);
    endtask

    initial begin
        #400000;
        check("watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 pulse after reset", int'(reset_pulse), 0);
        check("R1 source after reset", int'(reset_src), 0);

        // R4: fire write without arming
        bus_write(8'h05, 8'h00, 0);
        settle("R4 unarmed fire write");
        check("R4 source unchanged", int'(reset_src), 0);

        // R2: proper sequence
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h05, 8'h00, 1);
        settle("R2 command reset");
        check("R2 source command", int'(reset_src), 1);

        // R5: sequence idle after reset
        bus_write(8'h05, 8'h00, 0);
        settle("R5 idle after reset");

        // R3: nonzero arm write disarms
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h1E, 8'h55, 0);
        bus_write(8'h05, 8'h00, 0);
        settle("R3 nonzero arm");

        // R3: foreign address disarms
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h07, 8'h00, 0);
        bus_write(8'h05, 8'h00, 0);
        settle("R3 foreign address");

        // R3: nonzero fire write disarms
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h05, 8'h12, 0);
        bus_write(8'h05, 8'h00, 0);
        settle("R3 nonzero fire");

        // R3: repeated arm keeps armed; R11: strobe-less cycles ignored
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h1E, 8'h00, 0);
        @(posedge clk); #1;
        wr_addr = 8'h33; wr_data = 8'hFF;
        @(posedge clk); #1;
        wr_addr = 8'h1E; wr_data = 8'h01;
        @(posedge clk); #1;
        bus_write(8'h05, 8'h00, 1);
        settle("R3 R11 re-arm and idle bus");

        // R6: supply present with pin grounded counts nothing
        set_cond(1'b1, 1'b1);
        for (int i = 0; i < 20; i++) tick(0);
        set_cond(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) tick(0);
        settle("R6 one condition only");

        // R6: full hold
        set_cond(1'b0, 1'b1);
        for (int i = 1; i <= 15; i++) tick(i == 15);
        settle("R6 hardware reset");
        check("R6 source hardware", int'(reset_src), 2);

        // R8: hold continues
        for (int i = 0; i < 20; i++) tick(0);
        settle("R8 no repeat pulse");

        // R7: drop at 14 restarts
        set_cond(1'b1, 1'b0);
        set_cond(1'b0, 1'b1);
        for (int i = 0; i < 14; i++) tick(0);
        set_cond(1'b0, 1'b0);
        set_cond(1'b0, 1'b1);
        for (int i = 0; i < 14; i++) tick(0);
        settle("R7 restart after drop");
        tick(1);
        settle("R7 fires after full hold");

        // R10: command reset after hardware changes source
        set_cond(1'b1, 1'b0);
        bus_write(8'h1E, 8'h00, 0);
        bus_write(8'h05, 8'h00, 1);
        settle("R10 command after hardware");
        check("R10 source now command", int'(reset_src), 1);

        // R9: simultaneous fire
        bus_write(8'h1E, 8'h00, 0);
        set_cond(1'b0, 1'b1);
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #1 sec_tick = 1'b1;
            @(posedge clk); #1 sec_tick = 1'b0;
        end
        @(posedge clk); #1;
        sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 8'h05; wr_data = 8'h00;
        push(2'b10);
        @(posedge clk); #1;
        sec_tick = 1'b0; wr_en = 1'b0;
        settle("R9 simultaneous single pulse");
        check("R9 source hardware wins", int'(reset_src), 2);

        // R9: hardware reset disarms command sequence
        set_cond(1'b1, 1'b0);
        bus_write(8'h1E, 8'h00, 0);
        set_cond(1'b0, 1'b1);
        for (int i = 1; i <= 15; i++) tick(i == 15);
        set_cond(1'b1, 1'b0);
        bus_write(8'h05, 8'h00, 0);
        settle("R9 hardware reset disarms");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule